// File: doc/BRIEF.md
# Performance Monitor Counter Unit

The unit counts processor activity for profiling. It holds one free-running cycle counter and four programmable event counters, all 32 bits wide. A simple register port reads and writes them. Each event counter watches one line of a 128-line event bus, and a per-counter 7-bit code picks that line. The event counters share one pair of access registers. A selection register decides which counter that pair reaches. The cycle counter has its own count register.

Counter enables and interrupt enables are each held in one mask. Each mask has a write-one-to-set address and a write-one-to-clear address. A global control register turns all counting on or off. Its self-clearing bits zero the counters. It can also slow the cycle counter to one step in 64 clocks. A sticky overflow flag register records every wrap from all ones to zero. Software clears a flag by writing one to it. The interrupt output is a level. It stays high while any flag that has its interrupt enabled is set.

For sampling, software loads a counter with the two's complement of the period, so the flag sets after exactly that many counted events.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, every register and counter reads 0 and `irq` is low.
- R2: Control register at address 0x0: bit 0 global enable, bit 3 divide-by-64 for the cycle counter, bits 4 and 5 stored only. Writing bit 1 zeroes all event counters and writing bit 2 zeroes the cycle counter and its prescaler. Both take effect at that write's clock edge. Bits 1 and 2 and bits 31:6 always read 0.
- R3: Counter enable mask: write-one-to-set at 0x1, write-one-to-clear at 0x2. Bit 31 is the cycle counter and bits 3:0 are event counters 0 to 3. Zero bits and all other bits have no effect. Both addresses read back the mask.
- R4: Interrupt enable mask: write-one-to-set at 0x8, write-one-to-clear at 0x9. It uses the same bit layout and readback rules as R3.
- R5: Selection register at 0x4 (5 bits). The event code at 0x5 (7 bits) and the event count at 0x6 reach the selected event counter. If the selection is 4 or higher, both addresses read 0 and writes to them are ignored.
- R6: Event counter i advances by one at each clock edge where the global enable, its enable bit and event bus line `code_i` are all 1.
- R7: The cycle counter at 0x7 advances when the global enable and bit 31 of the enable mask are 1. This happens every clock, or once every 64 such clocks when bit 3 is set.
- R8: A wrap from 0xFFFFFFFF to 0 sets that counter's bit in the flag register at 0x3 at the same edge. Writing one to a flag clears it. A set and a clear at the same edge leave the flag set.
- R9: `irq` is high exactly while some flag bit and its interrupt-enable bit are both 1, and stays high until one of them is cleared.
- R10: A write to a count register at the same edge as an increment or a reset bit loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_bus | input | 128 | Event pulse lines, one per event code |
| irq | output | 1 | Level overflow interrupt |

## Verification
A write or a count step takes effect at the clock edge where it is presented. Because `reg_rdata` is a combinational view of the registers, the new value appears in the cycle after that edge. `irq` changes in the same cycle as the flag that drives it.

The bench applies each stimulus after a falling edge. It samples `reg_rdata` and `irq` one nanosecond later, before the next rising edge. It compares them with a behavioural model that has been advanced exactly once per rising edge. In this way every result is checked in the first cycle in which it is due.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int CNT_W   = 32;
    localparam int N_EVT   = 4;
    localparam int CODE_W  = 7;
    localparam int SEL_W   = 5;
    localparam int CTRL_W  = 6;
    localparam int PRE_W   = 6;
    localparam int ADDR_W  = 4;
    localparam int EVT_W   = 1 << CODE_W;

    // control bit positions
    localparam int C_RUN   = 0;
    localparam int C_EVRST = 1;
    localparam int C_CYRST = 2;
    localparam int C_DIV   = 3;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] A_ENSET = 4'h1;
    localparam logic [ADDR_W-1:0] A_ENCLR = 4'h2;
    localparam logic [ADDR_W-1:0] A_OVF   = 4'h3;
    localparam logic [ADDR_W-1:0] A_SEL   = 4'h4;
    localparam logic [ADDR_W-1:0] A_EVSEL = 4'h5;
    localparam logic [ADDR_W-1:0] A_EVCNT = 4'h6;
    localparam logic [ADDR_W-1:0] A_CYC   = 4'h7;
    localparam logic [ADDR_W-1:0] A_IESET = 4'h8;
    localparam logic [ADDR_W-1:0] A_IECLR = 4'h9;

    // packed per-counter mask: bit N_EVT is the cycle counter
    typedef logic [N_EVT:0] cmask_t;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        cmask_t            en;
        cmask_t            ie;
        cmask_t            flag;
        logic [SEL_W-1:0]  sel;
    } pmu_regs_t;

    function automatic cmask_t bus_to_mask(input logic [CNT_W-1:0] b);
        cmask_t m;
        m = {b[CNT_W-1], b[N_EVT-1:0]};
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] mask_to_bus(input cmask_t m);
        logic [CNT_W-1:0] b;
        b = '0;
        b[CNT_W-1]   = m[N_EVT];
        b[N_EVT-1:0] = m[N_EVT-1:0];
        return b;
    endfunction
endpackage

// File: rtl/pmu_event_ctr.sv
module pmu_event_ctr #(
    parameter int CNT_W  = 32,
    parameter int CODE_W = 7,
    parameter int EVT_W  = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic [EVT_W-1:0]  evt_bus,
    input  logic              code_we,
    input  logic              cnt_we,
    input  logic              clr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  cnt;
    } ectr_t;

    ectr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (code_we) st_d.code = wdata[CODE_W-1:0];
        if (cnt_we) begin
            st_d.cnt = wdata;
        end else if (clr) begin
            st_d.cnt = '0;
        end else if (count_en && evt_bus[st_q.code]) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap     = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code  = st_q.code;
    assign count = st_q.cnt;
endmodule

// File: rtl/pmu_cycle_ctr.sv
module pmu_cycle_ctr #(
    parameter int CNT_W = 32,
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             div,
    input  logic             cnt_we,
    input  logic             clr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } cctr_t;

    cctr_t st_d, st_q;
    logic  tick;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        tick = run && (!div || (&st_q.pre));
        if (clr)             st_d.pre = '0;
        else if (run && div) st_d.pre = st_q.pre + 1'b1;
        if (cnt_we) begin
            st_d.cnt = wdata;
        end else if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap     = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
    import pmu_pkg::*;
#(
    parameter int P_CNT_W  = CNT_W,
    parameter int P_CODE_W = CODE_W,
    parameter int P_EVT_W  = 1 << P_CODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [P_CNT_W-1:0]   reg_wdata,
    output logic [P_CNT_W-1:0]   reg_rdata,
    input  logic [P_EVT_W-1:0]   evt_bus,
    output logic                 irq
);
    localparam int IDX_W = $clog2(N_EVT);

    pmu_regs_t regs_d, regs_q;

    logic               wr_ctrl, wr_evsel, wr_evcnt, wr_cyc;
    logic               sel_ok, glob_en;
    logic [N_EVT-1:0]   ev_wrap;
    logic               cyc_wrap;
    logic [P_CNT_W-1:0] ev_cnt  [N_EVT];
    logic [P_CODE_W-1:0] ev_code [N_EVT];
    logic [P_CNT_W-1:0] cyc_count;
    cmask_t             ovf_flags;
    logic [SEL_W-1:0]   sel_val;

    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_evsel = reg_wr && (reg_addr == A_EVSEL);
    assign wr_evcnt = reg_wr && (reg_addr == A_EVCNT);
    assign wr_cyc   = reg_wr && (reg_addr == A_CYC);
    assign sel_ok   = (regs_q.sel < SEL_W'(N_EVT));
    assign glob_en  = regs_q.ctrl[C_RUN];

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        pmu_event_ctr #(
            .CNT_W (P_CNT_W),
            .CODE_W(P_CODE_W),
            .EVT_W (P_EVT_W)
        ) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .count_en(glob_en && regs_q.en[i]),
            .evt_bus (evt_bus),
            .code_we (wr_evsel && sel_ok && (regs_q.sel == SEL_W'(i))),
            .cnt_we  (wr_evcnt && sel_ok && (regs_q.sel == SEL_W'(i))),
            .clr     (wr_ctrl && reg_wdata[C_EVRST]),
            .wdata   (reg_wdata),
            .code    (ev_code[i]),
            .count   (ev_cnt[i]),
            .wrap    (ev_wrap[i])
        );
    end

    pmu_cycle_ctr #(
        .CNT_W(P_CNT_W),
        .PRE_W(PRE_W)
    ) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (glob_en && regs_q.en[N_EVT]),
        .div   (regs_q.ctrl[C_DIV]),
        .cnt_we(wr_cyc),
        .clr   (wr_ctrl && reg_wdata[C_CYRST]),
        .wdata (reg_wdata),
        .count (cyc_count),
        .wrap  (cyc_wrap)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) begin
            regs_d.ctrl = reg_wdata[CTRL_W-1:0];
            regs_d.ctrl[C_EVRST] = 1'b0;
            regs_d.ctrl[C_CYRST] = 1'b0;
        end
        if (reg_wr && reg_addr == A_ENSET) regs_d.en = regs_q.en |  bus_to_mask(reg_wdata);
        if (reg_wr && reg_addr == A_ENCLR) regs_d.en = regs_q.en & ~bus_to_mask(reg_wdata);
        if (reg_wr && reg_addr == A_IESET) regs_d.ie = regs_q.ie |  bus_to_mask(reg_wdata);
        if (reg_wr && reg_addr == A_IECLR) regs_d.ie = regs_q.ie & ~bus_to_mask(reg_wdata);
        if (reg_wr && reg_addr == A_SEL)   regs_d.sel = reg_wdata[SEL_W-1:0];
        regs_d.flag = regs_q.flag;
        if (reg_wr && reg_addr == A_OVF)   regs_d.flag = regs_q.flag & ~bus_to_mask(reg_wdata);
        regs_d.flag = regs_d.flag | {cyc_wrap, ev_wrap};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:          reg_rdata[CTRL_W-1:0] = regs_q.ctrl;
            A_ENSET, A_ENCLR: reg_rdata = mask_to_bus(regs_q.en);
            A_IESET, A_IECLR: reg_rdata = mask_to_bus(regs_q.ie);
            A_OVF:           reg_rdata = mask_to_bus(regs_q.flag);
            A_SEL:           reg_rdata[SEL_W-1:0] = regs_q.sel;
            A_EVSEL:         if (sel_ok) reg_rdata[P_CODE_W-1:0] = ev_code[regs_q.sel[IDX_W-1:0]];
            A_EVCNT:         if (sel_ok) reg_rdata = ev_cnt[regs_q.sel[IDX_W-1:0]];
            A_CYC:           reg_rdata = cyc_count;
            default:         reg_rdata = '0;
        endcase
    end

    assign irq       = |(regs_q.flag & regs_q.ie);
    assign ovf_flags = regs_q.flag;
    assign sel_val   = regs_q.sel;
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
    import pmu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [CNT_W-1:0]  reg_rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  cyc_count,
    input logic              cyc_flag,
    input logic              glob_en,
    input logic [SEL_W-1:0]  sel_val
);
    // R2: reset bits and upper bits of control never read back as 1
    p_ctrl_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> (reg_rdata[C_CYRST:C_EVRST] == 2'b00 && reg_rdata[CNT_W-1:CTRL_W] == '0));

    // R5: out-of-range selection reads zero on both selected registers
    p_sel_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr == A_EVSEL || reg_addr == A_EVCNT) && sel_val >= SEL_W'(N_EVT)) |-> (reg_rdata == '0));

    // R7: cycle counter is frozen while globally disabled and not written
    p_cyc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !(reg_wr && (reg_addr == A_CYC || reg_addr == A_CTRL))) |=> $stable(cyc_count));

    // R8: a cycle counter wrap leaves its flag set
    p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_count == '1 && !(reg_wr && (reg_addr == A_CYC || reg_addr == A_CTRL))) |=> (cyc_count != '0 || cyc_flag));

    // R9: interrupt stays high unless a flag or an interrupt enable is cleared
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && (reg_addr == A_OVF || reg_addr == A_IECLR))) |=> irq);
endmodule

bind perf_counter_unit pmu_checker u_pmu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .cyc_count(cyc_count),
    .cyc_flag (ovf_flags[pmu_pkg::N_EVT]),
    .glob_en  (glob_en),
    .sel_val  (sel_val)
);

// File: tb/tb_perf_counter_unit.sv
`timescale 1ns/1ps
module tb_perf_counter_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [127:0] evt_bus = '0;
    logic         irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    perf_counter_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_bus(evt_bus), .irq(irq)
    );

    // behavioural reference state
    localparam logic [31:0] MASK = 32'h8000000F;
    logic [31:0] m_ev [4];
    logic [6:0]  m_code [4];
    logic [31:0] m_cyc;
    int          m_pre;
    logic [5:0]  m_ctrl;
    logic [31:0] m_en, m_ie, m_fl;
    logic [4:0]  m_sel;

    task automatic m_reset();
        for (int i = 0; i < 4; i++) begin m_ev[i] = 0; m_code[i] = 0; end
        m_cyc = 0; m_pre = 0; m_ctrl = 0; m_en = 0; m_ie = 0; m_fl = 0; m_sel = 0;
    endtask

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'h0: return {26'd0, m_ctrl};
            4'h1, 4'h2: return m_en;
            4'h3: return m_fl;
            4'h4: return {27'd0, m_sel};
            4'h5: return (m_sel < 4) ? {25'd0, m_code[m_sel[1:0]]} : 32'd0;
            4'h6: return (m_sel < 4) ? m_ev[m_sel[1:0]] : 32'd0;
            4'h7: return m_cyc;
            4'h8, 4'h9: return m_ie;
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_step(input logic w, input logic [3:0] a, input logic [31:0] d, input logic [127:0] ev);
        logic [31:0] nev [4];
        logic [31:0] setf;
        logic [31:0] ncyc;
        int npre;
        logic glob, run, dv, tick;
        setf = 0;
        glob = m_ctrl[0];
        for (int i = 0; i < 4; i++) begin
            nev[i] = m_ev[i];
            if (w && a == 4'h6 && m_sel == i) nev[i] = d;
            else if (w && a == 4'h0 && d[1]) nev[i] = 0;
            else if (glob && m_en[i] && ev[m_code[i]]) begin
                if (m_ev[i] == 32'hFFFFFFFF) setf[i] = 1'b1;
                nev[i] = m_ev[i] + 1;
            end
        end
        run = glob && m_en[31];
        dv  = m_ctrl[3];
        tick = run && (!dv || m_pre == 63);
        npre = m_pre;
        if (w && a == 4'h0 && d[2]) npre = 0;
        else if (run && dv) npre = (m_pre + 1) % 64;
        ncyc = m_cyc;
        if (w && a == 4'h7) ncyc = d;
        else if (w && a == 4'h0 && d[2]) ncyc = 0;
        else if (tick) begin
            if (m_cyc == 32'hFFFFFFFF) setf[31] = 1'b1;
            ncyc = m_cyc + 1;
        end
        if (w && a == 4'h3) m_fl = m_fl & ~d;
        m_fl = m_fl | setf;
        if (w && a == 4'h5 && m_sel < 4) m_code[m_sel[1:0]] = d[6:0];
        if (w && a == 4'h0) m_ctrl = d[5:0] & 6'b111001;
        if (w && a == 4'h1) m_en = m_en | (d & MASK);
        if (w && a == 4'h2) m_en = m_en & ~(d & MASK);
        if (w && a == 4'h8) m_ie = m_ie | (d & MASK);
        if (w && a == 4'h9) m_ie = m_ie & ~(d & MASK);
        if (w && a == 4'h4) m_sel = d[4:0];
        for (int i = 0; i < 4; i++) m_ev[i] = nev[i];
        m_cyc = ncyc;
        m_pre = npre;
    endtask

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'h0: return "R2";
            4'h1, 4'h2: return "R3";
            4'h3: return "R8";
            4'h4, 4'h5: return "R5";
            4'h6: return "R6";
            4'h7: return "R7";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    logic [127:0] evt_next = '0;

    // one cycle: drive after the falling edge, compare before the rising edge
    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d, input string tag);
        reg_wr = w; reg_addr = a; reg_wdata = d; evt_bus = evt_next;
        #1;
        chk((tag != "") ? tag : tag_of(a), reg_rdata, m_read(a));
        chk("R9", {31'd0, irq}, {31'd0, |(m_fl & m_ie)});
        m_step(w, a, d, evt_next);
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(1'b0, a, 32'd0, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, a, d, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state over every address
        for (int a = 0; a < 10; a++) rd(4'(a), "R1");

        // R2: control readback and self-clearing reset bits
        wr(4'h0, 32'hFFFFFFFF, "R2");
        rd(4'h0, "R2");
        wr(4'h0, 32'h0, "R2");
        rd(4'h0, "R2");

        // R3: enable set/clear
        wr(4'h1, 32'hFFFFFFFF, "R3");
        rd(4'h1, "R3");
        wr(4'h2, 32'h00000005, "R3");
        rd(4'h2, "R3");
        wr(4'h2, 32'h7FFFFFF0, "R3");
        rd(4'h1, "R3");
        wr(4'h2, 32'hFFFFFFFF, "R3");
        rd(4'h1, "R3");

        // R4: interrupt enable set/clear
        wr(4'h8, 32'h0000F00A, "R4");
        rd(4'h9, "R4");
        wr(4'h9, 32'h00000002, "R4");
        rd(4'h8, "R4");
        wr(4'h9, 32'hFFFFFFFF, "R4");

        // R5: selection, code masking and out-of-range access
        wr(4'h4, 32'hFFFFFFE2, "R5");
        wr(4'h5, 32'h000000FF, "R5");
        rd(4'h5, "R5");
        wr(4'h4, 32'h00000007, "R5");
        wr(4'h5, 32'h00000011, "R5");
        wr(4'h6, 32'h12345678, "R5");
        rd(4'h5, "R5");
        rd(4'h6, "R5");
        for (int i = 0; i < 4; i++) begin
            wr(4'h4, 32'(i), "R5");
            rd(4'h6, "R5");
        end

        // R6: program counters near overflow and count random events
        for (int i = 0; i < 4; i++) begin
            wr(4'h4, 32'(i), "R5");
            wr(4'h5, 32'(i * 3 + 1), "R5");
            wr(4'h6, 32'hFFFFFFF0 + 32'(i), "R6");
        end
        wr(4'h1, 32'h8000000F, "R3");
        wr(4'h8, 32'h0000000F, "R4");
        wr(4'h7, 32'hFFFFFFF8, "R7");
        wr(4'h0, 32'h00000001, "R2");
        for (int k = 0; k < 80; k++) begin
            evt_next = {$urandom(), $urandom(), $urandom(), $urandom()};
            if (k % 5 == 4) wr(4'h4, 32'(k % 4), "R5");
            else rd(4'(6 + (k % 4 == 1) + 3 * (k % 4 == 2)), "");
        end
        evt_next = '1;
        for (int i = 0; i < 4; i++) begin
            wr(4'h4, 32'(i), "R5");
            rd(4'h6, "R6");
        end
        // R8 / R9: flags, then write-one-to-clear
        rd(4'h3, "R8");
        wr(4'h3, 32'h00000003, "R8");
        rd(4'h3, "R8");
        wr(4'h9, 32'h0000000C, "R9");
        rd(4'h3, "R9");
        wr(4'h3, 32'hFFFFFFFF, "R9");
        rd(4'h3, "R9");

        // R10: write beats increment in the same cycle
        wr(4'h4, 32'h0, "R5");
        wr(4'h6, 32'h00001234, "R10");
        reg_wr = 1'b0; reg_addr = 4'h6; #1;
        chk("R10", reg_rdata, 32'h00001234);
        @(negedge clk);
        m_step(1'b0, 4'h6, 32'd0, evt_next);
        rd(4'h6, "R10");
        wr(4'h7, 32'h0000ABCD, "R10");
        rd(4'h7, "R10");

        // R8: set wins over clear on the wrap edge
        wr(4'h8, 32'h80000000, "R8");
        wr(4'h7, 32'hFFFFFFFF, "R8");
        wr(4'h3, 32'h80000000, "R8");
        rd(4'h3, "R8");
        rd(4'h7, "R8");
        wr(4'h3, 32'h80000000, "R8");
        rd(4'h3, "R8");

        // R7: divide-by-64 from a cleared prescaler
        wr(4'h0, 32'h0000000D, "R7");
        for (int k = 0; k < 200; k++) rd(4'h7, "R7");
        wr(4'h0, 32'h00000001, "R7");
        for (int k = 0; k < 6; k++) rd(4'h7, "R7");

        // R2: event reset bit zeroes event counters, cycle keeps running
        wr(4'h0, 32'h00000003, "R2");
        for (int i = 0; i < 4; i++) begin
            wr(4'h4, 32'(i), "R5");
            rd(4'h6, "R2");
        end
        rd(4'h0, "R2");

        // R6 / R7: global disable freezes all counting
        wr(4'h0, 32'h0, "R2");
        for (int k = 0; k < 10; k++) begin
            evt_next = {$urandom(), $urandom(), $urandom(), $urandom()};
            rd((k % 2 == 0) ? 4'h7 : 4'h6, "");
        end
        // R3: per-counter disable
        wr(4'h0, 32'h1, "R2");
        wr(4'h2, 32'h80000000, "R3");
        for (int k = 0; k < 6; k++) rd(4'h7, "R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule